// File: doc/BRIEF.md
# Prioritized Reset State Manager

This block chooses among five reset sources and drives the processor and peripheral reset outputs. The sources are a backup-domain reset, a wake-up reset, a watchdog expiry, a software command and an active-low external reset pin. Which source wins depends on the fixed ranking of the sources and also on the reset already in progress. Some sources are shut out while certain resets run, and higher-ranked sources cut a running reset short and restart the pulse.

Each reset pulse lasts a programmable number of clock cycles. The block keeps a code for the most recent reset cause. It synchronises the external pin and reports the pin's level. It keeps a sticky flag for falling edges on the pin, and that flag can raise an interrupt when pin resets are disabled. Software reaches the block through a small register port:

- Address 0 (CMD) accepts commands.
- Address 1 (MODE) holds the user-reset enable, the interrupt enable and the pulse length.
- Address 2 (STAT) returns the status.

Top module: `rst_prio_mgr`

## Requirements
- R1: From idle, the requests seen in the same cycle are ranked from highest to lowest as backup_req, wake_req, wdog_req, software command, then pin falling edge with user reset enabled. Only the highest-ranked request is served. A software command written in the same cycle as wdog_req is lost.
- R2: A backup or wake-up request that arrives during a lower-ranked reset preempts that reset and restarts the pulse length. A request of lower or equal rank does not preempt.
- R3: During a user (pin) reset, wdog_req and software commands are ignored, and the pulse ends on its original schedule.
- R4: During a software reset, wdog_req moves the block into watchdog reset with a fresh pulse, and periph_rst is asserted from then on.
- R5: During a software reset, a falling edge on ext_rst_n has no effect on the reset outputs.
- R6: During a watchdog reset, software commands are rejected and a pin falling edge does not start a user reset.
- R7: A software reset command is a write to address 0 with bit 0 set. When the command is accepted, STAT bit 8 (busy) is set. The busy bit clears when the software pulse ends, and commands written while it is set are ignored.
- R8: STAT bits [2:0] hold the cause of the last reset: 0 backup, 1 wake-up, 2 watchdog, 3 software, 4 user. After power-on the field reads 0.
- R9: proc_rst stays high for max(L,2) cycles, where L is MODE bits [15:8] (reset value 4). periph_rst follows proc_rst, except that a software reset asserts it only when bit 1 of the command write is set.
- R10: STAT bit 16 gives ext_rst_n after a two-flop synchroniser. A change on the pin appears there two clock edges later.
- R11: A high-to-low transition of the synchronised pin sets STAT bit 17 (sticky). When MODE bit 0 (user reset enable) is set, the same transition starts a user reset, with proc_rst rising three edges after the pin falls.
- R12: irq equals the sticky bit AND MODE bit 1 (interrupt enable) AND NOT MODE bit 0. A read of STAT clears the sticky bit unless a new edge arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| backup_req | input | 1 | Backup-domain reset request, one-cycle pulse |
| wake_req | input | 1 | Wake-up reset request, one-cycle pulse |
| wdog_req | input | 1 | Watchdog expiry request, one-cycle pulse |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 command, 1 mode, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle reg_rd is high |
| proc_rst | output | 1 | Processor reset, active high |
| periph_rst | output | 1 | Peripheral reset, active high |
| irq | output | 1 | Pin-edge interrupt |

## Verification
Reset requests and register commands sampled at one edge show up on proc_rst and periph_rst one cycle later. A pulse of length L therefore occupies the next L cycles, and a preemption restarts that count from the preempting edge. Pin activity takes two edges to reach the level bit and three edges to reach the sticky bit, irq and a user reset. Status reads return data in the same cycle as reg_rd. The driver stamps each expected value with the cycle it is due in, and the monitor compares it at the falling edge of exactly that cycle. The monitor also looks past the point where a blocked or preempted source would have changed the outputs, which confirms the ignored stimulus had no effect.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BACKUP,
        ST_WAKE,
        ST_WDOG,
        ST_SOFT,
        ST_USER
    } rpm_state_e;

    typedef enum logic [2:0] {
        RT_BACKUP = 3'd0,
        RT_WAKE   = 3'd1,
        RT_WDOG   = 3'd2,
        RT_SOFT   = 3'd3,
        RT_USER   = 3'd4
    } rpm_type_e;

    // register map
    localparam int ADDR_CMD  = 0;
    localparam int ADDR_MODE = 1;
    localparam int ADDR_STAT = 2;

    // field positions
    localparam int CMD_GO_BIT     = 0;
    localparam int CMD_PERIPH_BIT = 1;
    localparam int MODE_UE_BIT    = 0;
    localparam int MODE_IE_BIT    = 1;
    localparam int MODE_LEN_LSB   = 8;
    localparam int STAT_BUSY_BIT  = 8;
    localparam int STAT_LVL_BIT   = 16;
    localparam int STAT_EDGE_BIT  = 17;

    function automatic rpm_type_e type_of(rpm_state_e s);
        case (s)
            ST_WAKE: return RT_WAKE;
            ST_WDOG: return RT_WDOG;
            ST_SOFT: return RT_SOFT;
            ST_USER: return RT_USER;
            default: return RT_BACKUP;
        endcase
    endfunction

endpackage

// File: rtl/rpm_pin_sync.sv
module rpm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic lvl,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[STAGES-2:0], pin_n};
        d.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign lvl  = q.sh[STAGES-1];
    assign fall = q.prev & ~q.sh[STAGES-1];

    // R11: an edge event lasts exactly one cycle
    a_r11_fall_single: assert property (@(posedge clk) disable iff (!por_n)
        fall |=> !fall);

endmodule

// File: rtl/rpm_arbiter.sv
module rpm_arbiter
    import rpm_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             backup_req,
    input  logic             wake_req,
    input  logic             wdog_req,
    input  logic             sw_cmd,
    input  logic             sw_periph,
    input  logic             user_evt,
    input  logic [LEN_W-1:0] len,
    output logic             proc_rst,
    output logic             periph_rst,
    output logic             sw_busy,
    output rpm_type_e        last_type
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

    typedef struct packed {
        rpm_state_e       st;
        logic [LEN_W-1:0] cnt;
        rpm_type_e        last;
        logic             busy;
        logic             periph;
    } arb_t;

    arb_t             q, d;
    logic             go;
    rpm_state_e       tgt;
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        len_eff = (len < MIN_LEN) ? MIN_LEN : len;
        go      = 1'b0;
        tgt     = ST_IDLE;
        case (q.st)
            ST_IDLE: begin
                go = 1'b1;
                if (backup_req)              tgt = ST_BACKUP;
                else if (wake_req)           tgt = ST_WAKE;
                else if (wdog_req)           tgt = ST_WDOG;
                else if (sw_cmd && !q.busy)  tgt = ST_SOFT;
                else if (user_evt)           tgt = ST_USER;
                else                         go  = 1'b0;
            end
            ST_WAKE: begin
                if (backup_req) begin go = 1'b1; tgt = ST_BACKUP; end
            end
            ST_WDOG, ST_USER: begin
                // watchdog cannot reach a user reset; neither admits commands
                if (backup_req)    begin go = 1'b1; tgt = ST_BACKUP; end
                else if (wake_req) begin go = 1'b1; tgt = ST_WAKE;   end
            end
            ST_SOFT: begin
                // pin edges are not looked at here
                if (backup_req)    begin go = 1'b1; tgt = ST_BACKUP; end
                else if (wake_req) begin go = 1'b1; tgt = ST_WAKE;   end
                else if (wdog_req) begin go = 1'b1; tgt = ST_WDOG;   end
            end
            default: ;
        endcase

        d = q;
        if (go) begin
            d.st     = tgt;
            d.cnt    = len_eff - 1'b1;
            d.last   = type_of(tgt);
            d.busy   = (tgt == ST_SOFT);
            d.periph = (tgt != ST_SOFT) || sw_periph;
        end else if (q.st != ST_IDLE) begin
            if (q.cnt == '0) begin
                d.st     = ST_IDLE;
                d.busy   = 1'b0;
                d.periph = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.st     <= ST_IDLE;
            q.cnt    <= '0;
            q.last   <= RT_BACKUP;
            q.busy   <= 1'b0;
            q.periph <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign proc_rst   = (q.st != ST_IDLE);
    assign periph_rst = q.periph;
    assign sw_busy    = q.busy;
    assign last_type  = q.last;

    // R1/R2: backup always wins the next cycle
    a_r1_backup_first: assert property (@(posedge clk) disable iff (!por_n)
        (backup_req && q.st != ST_BACKUP) |=> (q.st == ST_BACKUP));
    // R3: watchdog and commands cannot displace a user reset
    a_r3_user_holds: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_USER && !backup_req && !wake_req) |=> (last_type == RT_USER));
    // R4: watchdog preempts software reset
    a_r4_soft_to_wdog: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_SOFT && wdog_req && !backup_req && !wake_req) |=> (q.st == ST_WDOG && periph_rst));
    // R6: no software reset follows a watchdog reset directly
    a_r6_wdog_no_soft: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_WDOG) |=> !sw_busy);
    // R7: busy only while a reset is driven
    a_r7_busy_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        sw_busy |-> proc_rst);
    // R9: no pulse shorter than two cycles
    a_r9_min_pulse: assert property (@(posedge clk) disable iff (!por_n)
        $rose(proc_rst) |=> proc_rst);

endmodule

// File: rtl/rpm_regs.sv
module rpm_regs
    import rpm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2,
    parameter int LEN_W   = 8,
    parameter int LEN_RST = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pin_lvl,
    input  logic              pin_fall,
    input  rpm_type_e         last_type,
    input  logic              sw_busy,
    output logic              sw_cmd,
    output logic              sw_periph,
    output logic              user_evt,
    output logic [LEN_W-1:0]  len,
    output logic              irq
);
    typedef struct packed {
        logic             user_en;
        logic             irq_en;
        logic [LEN_W-1:0] len;
        logic             sticky;
    } regs_t;

    regs_t q, d;
    logic  sel_cmd, sel_mode, sel_stat;

    always_comb begin
        sel_cmd  = (reg_addr == ADDR_W'(ADDR_CMD));
        sel_mode = (reg_addr == ADDR_W'(ADDR_MODE));
        sel_stat = (reg_addr == ADDR_W'(ADDR_STAT));

        d = q;
        if (reg_wr && sel_mode) begin
            d.user_en = reg_wdata[MODE_UE_BIT];
            d.irq_en  = reg_wdata[MODE_IE_BIT];
            d.len     = reg_wdata[MODE_LEN_LSB +: LEN_W];
        end
        if (reg_rd && sel_stat) d.sticky = 1'b0;
        if (pin_fall)           d.sticky = 1'b1;

        reg_rdata = '0;
        if (reg_rd && sel_mode) begin
            reg_rdata[MODE_UE_BIT]               = q.user_en;
            reg_rdata[MODE_IE_BIT]               = q.irq_en;
            reg_rdata[MODE_LEN_LSB +: LEN_W]     = q.len;
        end else if (reg_rd && sel_stat) begin
            reg_rdata[2:0]           = last_type;
            reg_rdata[STAT_BUSY_BIT] = sw_busy;
            reg_rdata[STAT_LVL_BIT]  = pin_lvl;
            reg_rdata[STAT_EDGE_BIT] = q.sticky;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.user_en <= 1'b0;
            q.irq_en  <= 1'b0;
            q.len     <= LEN_W'(LEN_RST);
            q.sticky  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sw_cmd    = reg_wr && sel_cmd && reg_wdata[CMD_GO_BIT];
    assign sw_periph = reg_wdata[CMD_PERIPH_BIT];
    assign user_evt  = pin_fall && q.user_en;
    assign len       = q.len;
    assign irq       = q.sticky && q.irq_en && !q.user_en;

    // R11: every synchronised falling edge is recorded
    a_r11_edge_sets: assert property (@(posedge clk) disable iff (!por_n)
        pin_fall |=> q.sticky);
    // R12: a status read clears the flag when no edge coincides
    a_r12_read_clears: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rd && sel_stat && !pin_fall) |=> !irq);

endmodule

// File: rtl/rst_prio_mgr.sv
module rst_prio_mgr
    import rpm_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int LEN_W       = 8,
    parameter int LEN_RST     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              backup_req,
    input  logic              wake_req,
    input  logic              wdog_req,
    input  logic              ext_rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              proc_rst,
    output logic              periph_rst,
    output logic              irq
);
    logic             pin_lvl, pin_fall;
    logic             sw_cmd, sw_periph, user_evt, sw_busy;
    logic [LEN_W-1:0] len;
    rpm_type_e        last_type;

    rpm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .pin_n (ext_rst_n),
        .lvl   (pin_lvl),
        .fall  (pin_fall)
    );

    rpm_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .LEN_RST(LEN_RST)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_lvl   (pin_lvl),
        .pin_fall  (pin_fall),
        .last_type (last_type),
        .sw_busy   (sw_busy),
        .sw_cmd    (sw_cmd),
        .sw_periph (sw_periph),
        .user_evt  (user_evt),
        .len       (len),
        .irq       (irq)
    );

    rpm_arbiter #(.LEN_W(LEN_W)) u_arb (
        .clk        (clk),
        .por_n      (por_n),
        .backup_req (backup_req),
        .wake_req   (wake_req),
        .wdog_req   (wdog_req),
        .sw_cmd     (sw_cmd),
        .sw_periph  (sw_periph),
        .user_evt   (user_evt),
        .len        (len),
        .proc_rst   (proc_rst),
        .periph_rst (periph_rst),
        .sw_busy    (sw_busy),
        .last_type  (last_type)
    );

endmodule

// File: tb/rst_prio_mgr_tb_top.sv
`timescale 1ns/1ps
module rst_prio_mgr_tb_top;

    localparam int SEL_PROC = 0;
    localparam int SEL_PERI = 1;
    localparam int SEL_IRQ  = 2;
    localparam int SEL_RD   = 3;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        backup_req = 1'b0, wake_req = 1'b0, wdog_req = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        proc_rst, periph_rst, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] val;
        string       tag;
    } item_t;
    item_t sb_q[$];

    rst_prio_mgr dut_i (
        .clk(clk), .por_n(por_n), .backup_req(backup_req), .wake_req(wake_req),
        .wdog_req(wdog_req), .ext_rst_n(ext_rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .proc_rst(proc_rst), .periph_rst(periph_rst), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pick(int sel);
        case (sel)
            SEL_PROC: return {31'd0, proc_rst};
            SEL_PERI: return {31'd0, periph_rst};
            SEL_IRQ:  return {31'd0, irq};
            default:  return reg_rdata;
        endcase
    endfunction

    function automatic logic [31:0] stat(int t, bit b, bit l, bit s);
        return 32'(t) | (32'(b) << 8) | (32'(l) << 16) | (32'(s) << 17);
    endfunction

    // monitor: compare due items at the falling edge
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                n_chk++;
                if (pick(sb_q[i].sel) !== sb_q[i].val) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                             sb_q[i].tag, sb_q[i].sel, cyc, pick(sb_q[i].sel), sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic expect_at(int dly, int sel, logic [31:0] v, string tag);
        item_t it;
        it.due = cyc + dly;
        it.sel = sel;
        it.val = v;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        step();
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd_check(logic [31:0] v, string tag);
        reg_rd = 1'b1; reg_addr = 2'd2;
        expect_at(0, SEL_RD, v, tag);
        step();
        reg_rd = 1'b0;
    endtask

    task automatic set_mode(bit ue, bit ie, int len);
        wr(2'd1, (32'(len) << 8) | (ie ? 32'd2 : 32'd0) | (ue ? 32'd1 : 32'd0));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        steps(3);
        por_n = 1'b1;
        step();

        // reset state, R8: last cause reads backup
        expect_at(0, SEL_PROC, 0, "R9 reset");
        expect_at(0, SEL_PERI, 0, "R9 reset");
        expect_at(0, SEL_IRQ,  0, "R12 reset");
        rd_check(stat(0, 0, 1, 0), "R8 reset");

        // R1: watchdog beats a same-cycle command; R9 length 3
        set_mode(0, 0, 3);
        wdog_req = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
        expect_at(1, SEL_PROC, 1, "R1");
        expect_at(1, SEL_PERI, 1, "R9");
        expect_at(3, SEL_PROC, 1, "R9");
        expect_at(4, SEL_PROC, 0, "R9");
        step();
        wdog_req = 1'b0; reg_wr = 1'b0; reg_wdata = 32'd0;
        steps(4);
        rd_check(stat(2, 0, 1, 0), "R1 R8");

        // R2: backup preempts wake-up and restarts the count
        wake_req = 1'b1;
        expect_at(1, SEL_PROC, 1, "R2");
        expect_at(4, SEL_PROC, 1, "R2");
        expect_at(5, SEL_PROC, 0, "R2");
        step();
        wake_req = 1'b0; backup_req = 1'b1;
        step();
        backup_req = 1'b0;
        steps(4);
        rd_check(stat(0, 0, 1, 0), "R2 R8");

        // R9 minimum length, R7 busy and rejected repeat
        set_mode(0, 0, 0);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
        expect_at(1, SEL_PROC, 1, "R9");
        expect_at(1, SEL_PERI, 0, "R9");
        expect_at(2, SEL_PROC, 1, "R9");
        expect_at(3, SEL_PROC, 0, "R7");
        expect_at(4, SEL_PROC, 0, "R7");
        step();
        reg_wr = 1'b0; reg_wdata = 32'd0;
        rd_check(stat(3, 1, 1, 0), "R7");
        wr(2'd0, 32'd1);
        rd_check(stat(3, 0, 1, 0), "R7");
        steps(3);

        // R5: pin edge during software reset has no effect
        set_mode(1, 0, 4);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd3;
        expect_at(1, SEL_PROC, 1, "R5");
        expect_at(1, SEL_PERI, 1, "R9");
        expect_at(4, SEL_PROC, 1, "R5");
        expect_at(5, SEL_PROC, 0, "R5");
        expect_at(6, SEL_PROC, 0, "R5");
        step();
        reg_wr = 1'b0; reg_wdata = 32'd0; ext_rst_n = 1'b0;
        steps(4);
        ext_rst_n = 1'b1;
        steps(4);
        rd_check(stat(3, 0, 1, 1), "R11");
        rd_check(stat(3, 0, 1, 0), "R12");

        // R4: watchdog preempts software; R6: command during watchdog rejected
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
        expect_at(1, SEL_PERI, 0, "R4");
        expect_at(2, SEL_PERI, 1, "R4");
        expect_at(5, SEL_PROC, 1, "R4");
        expect_at(6, SEL_PROC, 0, "R4");
        expect_at(7, SEL_PROC, 0, "R6");
        step();
        reg_wr = 1'b0; wdog_req = 1'b1;
        step();
        wdog_req = 1'b0; reg_wr = 1'b1; reg_wdata = 32'd3;
        step();
        reg_wr = 1'b0; reg_wdata = 32'd0;
        rd_check(stat(2, 0, 1, 0), "R6");
        steps(5);

        // R6: pin edge during watchdog reset does not start a user reset
        wdog_req = 1'b1;
        expect_at(1, SEL_PROC, 1, "R6");
        expect_at(4, SEL_PROC, 1, "R6");
        expect_at(5, SEL_PROC, 0, "R6");
        expect_at(6, SEL_PROC, 0, "R6");
        step();
        wdog_req = 1'b0; ext_rst_n = 1'b0;
        steps(5);
        ext_rst_n = 1'b1;
        steps(4);
        rd_check(stat(2, 0, 1, 1), "R6");
        rd_check(stat(2, 0, 1, 0), "R12");

        // R11: user reset from pin; R3: watchdog and command ignored during it
        ext_rst_n = 1'b0;
        expect_at(2, SEL_PROC, 0, "R11");
        expect_at(3, SEL_PROC, 1, "R11");
        expect_at(3, SEL_PERI, 1, "R11");
        expect_at(6, SEL_PROC, 1, "R3");
        expect_at(7, SEL_PROC, 0, "R3");
        steps(4);
        wdog_req = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
        step();
        wdog_req = 1'b0; reg_wr = 1'b0; reg_wdata = 32'd0;
        steps(3);
        rd_check(stat(4, 0, 0, 1), "R3 R8");
        ext_rst_n = 1'b1;
        steps(4);
        rd_check(stat(4, 0, 1, 0), "R12");

        // R12: interrupt gating and clear on read
        set_mode(0, 1, 4);
        ext_rst_n = 1'b0;
        expect_at(2, SEL_IRQ, 0, "R12");
        expect_at(3, SEL_IRQ, 1, "R12");
        expect_at(4, SEL_PROC, 0, "R11");
        steps(4);
        expect_at(1, SEL_IRQ, 0, "R12");
        set_mode(1, 1, 4);
        expect_at(1, SEL_IRQ, 1, "R12");
        set_mode(0, 1, 4);
        expect_at(1, SEL_IRQ, 0, "R12");
        rd_check(stat(4, 0, 0, 1), "R12");
        ext_rst_n = 1'b1;
        steps(4);
        set_mode(0, 0, 4);

        // R10: level bit delay; R12 read/edge collision keeps the flag
        ext_rst_n = 1'b0;
        step();
        rd_check(stat(4, 0, 1, 0), "R10");
        rd_check(stat(4, 0, 0, 0), "R10");
        rd_check(stat(4, 0, 0, 1), "R12");
        ext_rst_n = 1'b1;
        steps(4);
        rd_check(stat(4, 0, 1, 0), "R10");

        steps(4);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard all-requirements actual=%0d expected=0 pending", sb_q.size());
        end
        finish_run();
    end

endmodule